// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command state machine that sits between a CPU bus and a small on-chip flash array. Once software sets the rewrite-enable input, byte writes on the bus are read as command codes. Some codes act in a single bus cycle and others need a second write. Decoded commands choose what a bus read returns, either the array byte at the read address or the status byte. They also start word program, block erase and whole-array erase operations.

The array is a behavioural byte store inside the block. Program and erase latencies are fixed counts of clock cycles set by parameters. While an operation runs, the ready output is low and the read path shows the status byte. When the operation completes, ready goes high again. Programming can only turn bits from 1 to 0, and a program that asks for a 0-to-1 change raises a program-error flag. An erase returns every byte in its scope to 0xFF.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rewrite_en` is 0, bus writes have no effect. No mode change, no operation start and no status change result from them.
- R2: After reset, the block is in array-read mode and every array byte is 0xFF. Writing 0xFF selects array-read mode, in which `rdata` shows the byte at `bus_addr` in the same cycle while `rd_en` is 1. Whenever `rd_en` is 0, `rdata` is 0x00.
- R3: Writing 0x70 selects status-read mode. The status byte carries ready in bit 7, the erase-error flag in bit 5 and the program-error flag in bit 4. All other bits read 0.
- R4: A single write of 0x50 clears both error flags and leaves the read mode unchanged.
- R5: A write of 0x40 followed by a write of address and data starts a program. Ready is low for exactly PROG_CYC cycles, counted from the clock edge of the second write. Afterwards the byte holds its old value ANDed with the data.
- R6: Starting any program or erase switches the block to status-read mode. It stays in that mode until the next accepted command.
- R7: If the program data has a 1 where the old byte has a 0, the program-error flag (status bit 4) is set when the program completes.
- R8: A write of 0x20 followed by a second write of 0x20 erases the whole array to 0xFF. Ready is low for exactly ERASE_CYC cycles.
- R9: A write of 0x20 followed by 0xD0 erases one block to 0xFF. The block is named by the upper address bits of the second write, and the bench gives the block's highest address. Bytes outside that block keep their values.
- R10: After 0x20, a second code other than 0x20 or 0xD0 sets both error flags and selects array-read mode. It erases nothing and ready stays high.
- R11: Bus writes that arrive while ready is low are ignored, including partial command sequences.
- R12: First-cycle codes other than 0xFF, 0x70, 0x50, 0x40 and 0x20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rewrite_en | input | 1 | Enables command decoding of bus writes |
| bus_addr | input | AW | Byte address for reads and command writes |
| wdata | input | 8 | Write data / command code |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| rdata | output | 8 | Array byte or status byte |
| ready | output | 1 | 1 when idle, 0 while program or erase runs |

## Verification
A wrong decoder state shows up on the next bus read. If the block is stuck waiting for a second cycle, a later single-cycle command is consumed as program data, and every array sweep then shows a corrupted byte. A stuck or early busy counter shows at the port as ready changing one or more cycles from the expected edge. Every such edge is checked at exact cycle offsets. A missed bit in the program merge, or an erase scope that is off by one, appears in the full-array sweep that follows each operation.

// File: rtl/flash_cmd_pkg.sv
// Package: shared codes and types for the flash command controller.
// Assumes an 8-bit data bus; command codes are fixed byte values.
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM     = 8'h40;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_BLK_CONFIRM = 8'hD0;

    typedef enum logic [1:0] {
        SEQ_FIRST      = 2'd0,
        SEQ_PROG_WAIT  = 2'd1,
        SEQ_ERASE_WAIT = 2'd2
    } seq_state_t;

    typedef enum logic {
        RD_ARRAY  = 1'b0,
        RD_STATUS = 1'b1
    } rd_mode_t;

endpackage

// File: rtl/flash_op_timer.sv
// Module: flash_op_timer
// Counts the latency of a program or erase. On a start strobe it loads
// PROG_CYC or ERASE_CYC. Busy stays high for exactly that many cycles.
// Done pulses in the last busy cycle. Assumes starts only arrive while idle.
module flash_op_timer #(
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(ERASE_CYC + 1);

    logic [TW-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= is_erase ? TW'(ERASE_CYC) : TW'(PROG_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TW'(1));

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);                                  // R11
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);                                   // R5
endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder
// Command state machine. It takes accepted bus writes, tracks the
// one- and two-cycle sequences, holds the read mode and the two error
// flags, and raises one-cycle start strobes. Assumes prog_fail only
// pulses while busy, so it never meets an accepted write.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rewrite_en,
    input  logic       busy,
    input  logic [7:0] wdata,
    input  logic       prog_fail,
    output rd_mode_t   mode,
    output logic       err_prog,
    output logic       err_erase,
    output logic       start_prog,
    output logic       start_blk,
    output logic       start_all
);
    seq_state_t state_q;
    rd_mode_t   mode_q;
    logic       err_prog_q, err_erase_q;
    logic       accept;

    assign accept = wr_en && rewrite_en && !busy;

    // Start strobes from the second cycle of a valid sequence.
    always_comb begin
        start_prog = 1'b0;
        start_blk  = 1'b0;
        start_all  = 1'b0;
        if (accept) begin
            if (state_q == SEQ_PROG_WAIT) begin
                start_prog = 1'b1;
            end else if (state_q == SEQ_ERASE_WAIT) begin
                start_all = (wdata == CMD_ERASE);
                start_blk = (wdata == CMD_BLK_CONFIRM);
            end
        end
    end

    // Sequence state, read mode and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_FIRST;
            mode_q      <= RD_ARRAY;
            err_prog_q  <= 1'b0;
            err_erase_q <= 1'b0;
        end else begin
            if (prog_fail) begin
                err_prog_q <= 1'b1;
            end
            if (accept) begin
                case (state_q)
                    SEQ_FIRST: begin
                        case (wdata)
                            CMD_READ_ARRAY:  mode_q  <= RD_ARRAY;
                            CMD_READ_STATUS: mode_q  <= RD_STATUS;
                            CMD_CLEAR_ERR: begin
                                err_prog_q  <= 1'b0;
                                err_erase_q <= 1'b0;
                            end
                            CMD_PROGRAM:     state_q <= SEQ_PROG_WAIT;
                            CMD_ERASE:       state_q <= SEQ_ERASE_WAIT;
                            default: ;
                        endcase
                    end
                    SEQ_PROG_WAIT: begin
                        state_q <= SEQ_FIRST;
                        mode_q  <= RD_STATUS;
                    end
                    SEQ_ERASE_WAIT: begin
                        state_q <= SEQ_FIRST;
                        if (wdata == CMD_ERASE || wdata == CMD_BLK_CONFIRM) begin
                            mode_q <= RD_STATUS;
                        end else begin
                            err_prog_q  <= 1'b1;
                            err_erase_q <= 1'b1;
                            mode_q      <= RD_ARRAY;
                        end
                    end
                    default: state_q <= SEQ_FIRST;
                endcase
            end
        end
    end

    assign mode      = mode_q;
    assign err_prog  = err_prog_q;
    assign err_erase = err_erase_q;

    AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rewrite_en) |=> ($stable(mode_q) && $stable(state_q)));       // R1
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(mode_q) && $stable(state_q)));              // R11
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == SEQ_FIRST && wdata == CMD_CLEAR_ERR)
        |=> (!err_prog_q && !err_erase_q));                                      // R4
    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == SEQ_ERASE_WAIT && wdata != CMD_ERASE
         && wdata != CMD_BLK_CONFIRM)
        |=> (err_prog_q && err_erase_q && mode_q == RD_ARRAY));                  // R10
    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_blk, start_all}));                           // R9
endmodule

// File: rtl/flash_array.sv
// Module: flash_array
// Behavioural byte store. A start strobe latches the operation. The
// store is changed on the done pulse: a program ANDs the data into one
// byte and an erase sets a block, or everything, to 0xFF. Reads are
// combinational. Assumes a block is 2**BLK_AW bytes, aligned.
module flash_array #(
    parameter int AW     = 6,
    parameter int BLK_AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_blk,
    input  logic          start_all,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    op_data,
    input  logic          op_done,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic          prog_fail
);
    localparam int DEPTH = 1 << AW;
    localparam int BW    = AW - BLK_AW;

    typedef enum logic [1:0] {OP_PROG, OP_BLK, OP_ALL} op_kind_t;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    op_kind_t      kind_q;

    // Latch the operation when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= 8'hFF;
            kind_q <= OP_PROG;
        end else if (start_prog || start_blk || start_all) begin
            addr_q <= op_addr;
            data_q <= op_data;
            kind_q <= start_prog ? OP_PROG : (start_blk ? OP_BLK : OP_ALL);
        end
    end

    // Apply the operation to the store on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (op_done) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kind_q == OP_ALL) begin
                    mem[i] <= 8'hFF;
                end else if (kind_q == OP_BLK
                             && AW'(i) >> BLK_AW == AW'(addr_q[AW-1 -: BW])) begin
                    mem[i] <= 8'hFF;
                end else if (kind_q == OP_PROG && AW'(i) == addr_q) begin
                    mem[i] <= mem[i] & data_q;
                end
            end
        end
    end

    assign rd_byte   = mem[rd_addr];
    assign prog_fail = op_done && (kind_q == OP_PROG)
                       && ((mem[addr_q] & data_q) != data_q);

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && kind_q == OP_PROG) |=> ((mem[addr_q] & ~data_q) == 8'h00));  // R5
    AST_ERASE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && kind_q != OP_PROG) |=> (mem[addr_q] == 8'hFF));              // R8
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// Connects the decoder, the latency timer and the array, and selects
// the read data (array byte or status byte). Assumes one bus write per
// clock at most and a synchronous active-low reset.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BLK_AW    = 4,
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rewrite_en,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [7:0]    rdata,
    output logic          ready
);
    rd_mode_t   mode;
    logic       err_prog, err_erase;
    logic       start_prog, start_blk, start_all;
    logic       busy, done, prog_fail;
    logic [7:0] arr_byte, status_byte;

    flash_cmd_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rewrite_en (rewrite_en),
        .busy       (busy),
        .wdata      (wdata),
        .prog_fail  (prog_fail),
        .mode       (mode),
        .err_prog   (err_prog),
        .err_erase  (err_erase),
        .start_prog (start_prog),
        .start_blk  (start_blk),
        .start_all  (start_all)
    );

    flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_prog || start_blk || start_all),
        .is_erase (start_blk || start_all),
        .busy     (busy),
        .done     (done)
    );

    flash_array #(.AW(AW), .BLK_AW(BLK_AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_blk  (start_blk),
        .start_all  (start_all),
        .op_addr    (bus_addr),
        .op_data    (wdata),
        .op_done    (done),
        .rd_addr    (bus_addr),
        .rd_byte    (arr_byte),
        .prog_fail  (prog_fail)
    );

    // Status byte layout: ready, 0, erase error, program error, 0000.
    assign status_byte = {!busy, 1'b0, err_erase, err_prog, 4'b0000};
    assign ready       = !busy;

    // Read data select.
    always_comb begin
        if (!rd_en) begin
            rdata = 8'h00;
        end else if (mode == RD_STATUS) begin
            rdata = status_byte;
        end else begin
            rdata = arr_byte;
        end
    end

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mode == RD_STATUS));                     // R6
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int AW        = 6;
    localparam int BLK_AW    = 4;
    localparam int PROG_CYC  = 10;
    localparam int ERASE_CYC = 48;
    localparam int DEPTH     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rewrite_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rdata;
    logic          ready;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [DEPTH];
    logic exp_ep = 1'b0;
    logic exp_ee = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC),
                     .ERASE_CYC(ERASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rewrite_en(rewrite_en), .bus_addr(bus_addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .ready(ready)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic rdy);
        return {rdy, 1'b0, exp_ee, exp_ep, 4'b0000};
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        #2 v = rdata;
    endtask

    // Select array mode and compare every byte with the model.
    task automatic sweep(input string req);
        logic [7:0] v;
        bus_write('0, 8'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            read_at(AW'(i), v);
            check(req, v, model[i]);
        end
    endtask

    // Check ready stays low for exactly n cycles after the last write edge.
    task automatic busy_window(input string req, input int n);
        check(req, {7'd0, ready}, 8'd0);
        repeat (n - 1) @(negedge clk);
        check(req, {7'd0, ready}, 8'd0);
        @(negedge clk);
        check(req, {7'd0, ready}, 8'd1);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, input string req);
        bus_write('0, 8'h40);
        bus_write(a, d);
        busy_window(req, PROG_CYC);
        if ((model[a] & d) != d) exp_ep = 1'b1;
        model[a] = model[a] & d;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, array mode, all bytes erased, rd_en gating
        check("R2", {7'd0, ready}, 8'd1);
        @(negedge clk); bus_addr = 6'd9; rd_en = 1'b0; #2 check("R2", rdata, 8'h00);
        for (int i = 0; i < DEPTH; i++) begin
            read_at(AW'(i), v);
            check("R2", v, 8'hFF);
        end

        rewrite_en = 1'b1;

        // R3: status read after 0x70
        bus_write('0, 8'h70);
        read_at(6'd3, v);
        check("R3", v, 8'h80);

        // R5: program every address with a computed pattern
        for (int i = 0; i < DEPTH; i++) begin
            program_byte(AW'(i), 8'((i * 29 + 3) ^ (i << 2)), "R5");
            read_at(AW'(i), v);
            check("R6", v, exp_status(1'b1));
        end
        sweep("R5");

        // R7: program a 1 into a cleared bit
        program_byte(6'd3, 8'hFF, "R5");
        read_at(6'd3, v);
        check("R7", v, exp_status(1'b1));
        check("R7", {7'd0, exp_ep}, 8'd1);

        // R4: clear flags, mode stays status
        bus_write('0, 8'h50);
        exp_ep = 1'b0; exp_ee = 1'b0;
        read_at(6'd0, v);
        check("R4", v, 8'h80);

        // R12: unknown first codes ignored in array mode
        bus_write('0, 8'hFF);
        bus_write('0, 8'h11);
        bus_write('0, 8'hD0);
        read_at(6'd5, v);
        check("R12", v, model[5]);
        bus_write(6'd6, 8'h00);
        check("R12", {7'd0, ready}, 8'd1);
        read_at(6'd6, v);
        check("R12", v, model[6]);

        // R1: writes ignored while rewrite disabled
        rewrite_en = 1'b0;
        bus_write('0, 8'h70);
        read_at(6'd7, v);
        check("R1", v, model[7]);
        bus_write('0, 8'h40);
        bus_write(6'd7, 8'h00);
        check("R1", {7'd0, ready}, 8'd1);
        read_at(6'd7, v);
        check("R1", v, model[7]);
        rewrite_en = 1'b1;

        // R9: block erase with the block's highest address
        bus_write('0, 8'h20);
        bus_write(6'h2F, 8'hD0);
        busy_window("R9", ERASE_CYC);
        for (int i = 32; i < 48; i++) model[i] = 8'hFF;
        read_at(6'd0, v);
        check("R6", v, 8'h80);
        sweep("R9");

        // R10: invalid confirm code
        bus_write('0, 8'h20);
        bus_write(6'h0F, 8'h33);
        check("R10", {7'd0, ready}, 8'd1);
        exp_ep = 1'b1; exp_ee = 1'b1;
        read_at(6'd2, v);
        check("R10", v, model[2]);
        bus_write('0, 8'h70);
        read_at(6'd2, v);
        check("R10", v, 8'hB0);
        sweep("R10");
        bus_write('0, 8'h50);
        exp_ep = 1'b0; exp_ee = 1'b0;

        // R11: writes during busy ignored
        bus_write('0, 8'h40);
        bus_write(6'd10, 8'h0F);
        bus_write('0, 8'hFF);
        bus_write('0, 8'h40);
        bus_write(6'd11, 8'h00);
        if ((model[10] & 8'h0F) != 8'h0F) exp_ep = 1'b1;
        model[10] = model[10] & 8'h0F;
        for (int k = 0; k < 100 && !ready; k++) @(negedge clk);
        check("R11", {7'd0, ready}, 8'd1);
        read_at(6'd11, v);
        check("R11", v, exp_status(1'b1));
        bus_write(6'd12, 8'h00);
        sweep("R11");
        bus_write('0, 8'h50);
        exp_ep = 1'b0; exp_ee = 1'b0;

        // R8: whole-array erase
        bus_write('0, 8'h20);
        bus_write(6'd1, 8'h20);
        busy_window("R8", ERASE_CYC);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        read_at(6'd1, v);
        check("R8", v, 8'h80);
        sweep("R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule